// File: doc/BRIEF.md
# Character LCD 4-Bit Power-Up Sequencer

This block takes a character LCD controller from its unknown power-on state into 4-bit interface mode. It runs after reset or after a restart request. It waits for the display supply to settle, then issues four timed instruction writes on a 4-bit data bus. The first three writes carry the 8-bit-mode nibble and the last carries the 4-bit-mode nibble. Each write is a strobe of fixed length on the enable line, and each is followed by its own settling wait. When the last wait has run out, a ready level tells the rest of the display path that normal commands may follow.

All waits and the strobe length are counts of clock cycles set by parameters. The defaults suit a 50 MHz clock: 750,000 cycles after power-up, then 205,000, 5,000, 2,000 and 2,000 cycles after the four writes, and a 12-cycle strobe. One down-counter times every phase. The data nibble is placed on the bus a set number of cycles before the strobe rises, and it is held through the whole following wait, so setup and hold at the display are met. Register select and read/write stay low throughout, because every write is an instruction write.

Top module: `lcd_nibble_init`

## Requirements
- R1: While `rst_n` is low, `lcd_en`, `lcd_rs`, `lcd_rw`, `lcd_ready` and all four bits of `lcd_data` are low. Reset acts on the outputs without waiting for a clock edge.
- R2: A `restart` sampled high at a clock edge aborts any run in progress. It also aborts a finished run. Directly after that edge `lcd_en` and `lcd_ready` are low, and the power-up wait starts again.
- R3: The first `lcd_en` high cycle comes PWRUP_CYC + SETUP_CYC cycles after the edge that sampled `restart`. The defaults are 750,000 and 1.
- R4: A run has exactly four strobes. The nibble on `lcd_data[3:0]` is 0x3 for strobes one to three and 0x2 for strobe four.
- R5: `lcd_en` stays high for exactly STROBE_CYC consecutive cycles on every strobe (default 12).
- R6: The low time of `lcd_en` between strobe k and strobe k+1 is GAPk_CYC + SETUP_CYC cycles. The defaults are GAP1 205,000, GAP2 5,000 and GAP3 2,000.
- R7: `lcd_data` holds its new nibble for at least SETUP_CYC cycles before `lcd_en` rises. It does not change while `lcd_en` is high, or in the cycle after `lcd_en` falls.
- R8: `lcd_rs` and `lcd_rw` are low at every strobe, so each write is an instruction write.
- R9: `lcd_ready` rises GAP4_CYC cycles after the fourth strobe falls (default 2,000). It then stays high, with no further strobe, until `restart` or reset.
- R10: `lcd_en` and `lcd_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 50 MHz for the default counts |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released through a two-stage synchronizer |
| restart | input | 1 | Synchronous request to rerun the whole sequence from the power-up wait |
| lcd_data | output | 4 | Nibble driven to the display data lines |
| lcd_en | output | 1 | Write strobe to the display |
| lcd_rs | output | 1 | Register select, held low |
| lcd_rw | output | 1 | Read/write select, held low |
| lcd_ready | output | 1 | Level: initialization finished, display accepts commands |

## Verification
The assertions assume that `restart` is synchronous to `clk`. They also assume that every timing parameter is at least one, so each phase lasts at least one cycle. The ready-hold property expects that `restart` is the only way, apart from reset, to leave the finished state. The bench changes `restart` and `rst_n` only just after a rising edge, and it uses small nonzero parameter values that differ from one another. A wait that is timed against the wrong parameter therefore shows up as a wrong cycle count. Restarts and an asynchronous reset are issued during a strobe, during a wait and after completion, so each abort path is reached.

// File: rtl/lcd_init_pkg.sv
`timescale 1ns/1ps
package lcd_init_pkg;
  typedef enum logic [2:0] {
    ST_POWER = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_GAP   = 3'd3,
    ST_DONE  = 3'd4
  } init_state_t;

  localparam int unsigned NUM_WRITES = 4;
  localparam logic [3:0]  NIB_WIDE   = 4'h3;
  localparam logic [3:0]  NIB_NARROW = 4'h2;
endpackage

// File: rtl/lcd_init_timer.sv
`timescale 1ns/1ps
module lcd_init_timer #(
  parameter int unsigned CW      = 20,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  cnt_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/lcd_init_seq.sv
`timescale 1ns/1ps
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned CW         = 20,
  parameter int unsigned PWRUP_CYC  = 750000,
  parameter int unsigned GAP1_CYC   = 205000,
  parameter int unsigned GAP2_CYC   = 5000,
  parameter int unsigned GAP3_CYC   = 2000,
  parameter int unsigned GAP4_CYC   = 2000,
  parameter int unsigned STROBE_CYC = 12,
  parameter int unsigned SETUP_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          en_nx,
  output logic          ready_nx,
  output logic          data_ld,
  output logic [3:0]    data_nx
);
  localparam int unsigned SW = $clog2(NUM_WRITES);
  localparam logic [SW-1:0] LAST = SW'(NUM_WRITES - 1);

  init_state_t   state_q, state_d;
  logic [SW-1:0] step_q, step_d;

  function automatic logic [CW-1:0] gap_len(input logic [SW-1:0] s);
    unique case (s)
      SW'(0):  gap_len = CW'(GAP1_CYC - 1);
      SW'(1):  gap_len = CW'(GAP2_CYC - 1);
      SW'(2):  gap_len = CW'(GAP3_CYC - 1);
      default: gap_len = CW'(GAP4_CYC - 1);
    endcase
  endfunction

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    load     = 1'b0;
    load_val = '0;
    if (restart) begin
      state_d  = ST_POWER;
      step_d   = '0;
      load     = 1'b1;
      load_val = CW'(PWRUP_CYC - 1);
    end else if (zero) begin
      case (state_q)
        ST_POWER: begin
          state_d  = ST_SETUP;
          load     = 1'b1;
          load_val = CW'(SETUP_CYC - 1);
        end
        ST_SETUP: begin
          state_d  = ST_PULSE;
          load     = 1'b1;
          load_val = CW'(STROBE_CYC - 1);
        end
        ST_PULSE: begin
          state_d  = ST_GAP;
          load     = 1'b1;
          load_val = gap_len(step_q);
        end
        ST_GAP: begin
          if (step_q == LAST) begin
            state_d = ST_DONE;
          end else begin
            state_d  = ST_SETUP;
            step_d   = step_q + 1'b1;
            load     = 1'b1;
            load_val = CW'(SETUP_CYC - 1);
          end
        end
        ST_DONE: state_d = ST_DONE;
        default: begin
          state_d  = ST_POWER;
          step_d   = '0;
          load     = 1'b1;
          load_val = CW'(PWRUP_CYC - 1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWER;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign en_nx    = (state_d == ST_PULSE);
  assign ready_nx = (state_d == ST_DONE);
  assign data_ld  = (state_d == ST_SETUP) && (state_q != ST_SETUP);
  assign data_nx  = (step_d == LAST) ? NIB_NARROW : NIB_WIDE;

  // R9
  last_gap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && zero && step_q == LAST && !restart) |=> state_q == ST_DONE);

  // R2
  restart_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == ST_POWER && step_q == '0));

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP && state_d == ST_SETUP) |=> step_q == $past(step_q) + 1'b1);
endmodule

// File: rtl/lcd_init_drive.sv
`timescale 1ns/1ps
module lcd_init_drive #(
  parameter int unsigned STROBE_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_nx,
  input  logic       ready_nx,
  input  logic       data_ld,
  input  logic [3:0] data_nx,
  output logic       en_q,
  output logic       ready_q,
  output logic [3:0] data_q
);
  localparam int unsigned HW = $clog2(STROBE_CYC + 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      en_q    <= en_nx;
      ready_q <= ready_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_ld) data_q <= data_nx;
  end

  // strobe length tracker for the width check below
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run <= '0;
    else if (en_q) hi_run <= hi_run + 1'b1;
    else           hi_run <= '0;
  end

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (hi_run < HW'(STROBE_CYC)));

  // R7
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $stable(data_q));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q || $fell(en_q)) |-> $stable(data_q));

  // R10
  en_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_q && ready_q));
endmodule

// File: rtl/lcd_nibble_init.sv
`timescale 1ns/1ps
module lcd_nibble_init #(
  parameter int unsigned PWRUP_CYC  = 750000,
  parameter int unsigned GAP1_CYC   = 205000,
  parameter int unsigned GAP2_CYC   = 5000,
  parameter int unsigned GAP3_CYC   = 2000,
  parameter int unsigned GAP4_CYC   = 2000,
  parameter int unsigned STROBE_CYC = 12,
  parameter int unsigned SETUP_CYC  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  output logic [3:0] lcd_data,
  output logic       lcd_en,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_ready
);
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    max2 = (a > b) ? a : b;
  endfunction

  localparam int unsigned MAXLEN = max2(max2(max2(PWRUP_CYC, GAP1_CYC), max2(GAP2_CYC, GAP3_CYC)),
                                        max2(max2(GAP4_CYC, STROBE_CYC), SETUP_CYC));
  localparam int unsigned CW = $clog2(MAXLEN + 1);

  // reset: asserts at once, releases on the second clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic          load, zero, en_nx, ready_nx, data_ld;
  logic [CW-1:0] load_val;
  logic [3:0]    data_nx;

  lcd_init_timer #(
    .CW      (CW),
    .RST_VAL (PWRUP_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load),
    .load_val (load_val),
    .zero     (zero)
  );

  lcd_init_seq #(
    .CW         (CW),
    .PWRUP_CYC  (PWRUP_CYC),
    .GAP1_CYC   (GAP1_CYC),
    .GAP2_CYC   (GAP2_CYC),
    .GAP3_CYC   (GAP3_CYC),
    .GAP4_CYC   (GAP4_CYC),
    .STROBE_CYC (STROBE_CYC),
    .SETUP_CYC  (SETUP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (restart),
    .zero     (zero),
    .load     (load),
    .load_val (load_val),
    .en_nx    (en_nx),
    .ready_nx (ready_nx),
    .data_ld  (data_ld),
    .data_nx  (data_nx)
  );

  lcd_init_drive #(
    .STROBE_CYC (STROBE_CYC)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_nx    (en_nx),
    .ready_nx (ready_nx),
    .data_ld  (data_ld),
    .data_nx  (data_nx),
    .en_q     (lcd_en),
    .ready_q  (lcd_ready),
    .data_q   (lcd_data)
  );

  assign lcd_rs = 1'b0;
  assign lcd_rw = 1'b0;

  // R9
  ready_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lcd_ready && !restart) |=> lcd_ready);

  // R2
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> (!lcd_en && !lcd_ready));
endmodule

// File: tb/lcd_nibble_init_test.sv
`timescale 1ns/1ps
module lcd_nibble_init_test;
  localparam int P  = 30;
  localparam int G1 = 17;
  localparam int G2 = 11;
  localparam int G3 = 7;
  localparam int G4 = 5;
  localparam int W  = 4;
  localparam int SU = 2;

  logic       clk = 1'b0;
  logic       rst_n, restart;
  logic [3:0] lcd_data;
  logic       lcd_en, lcd_rs, lcd_rw, lcd_ready;

  always #2.5 clk = ~clk;

  lcd_nibble_init #(
    .PWRUP_CYC (P), .GAP1_CYC (G1), .GAP2_CYC (G2), .GAP3_CYC (G3),
    .GAP4_CYC (G4), .STROBE_CYC (W), .SETUP_CYC (SU)
  ) uut (
    .clk (clk), .rst_n (rst_n), .restart (restart),
    .lcd_data (lcd_data), .lcd_en (lcd_en), .lcd_rs (lcd_rs),
    .lcd_rw (lcd_rw), .lcd_ready (lcd_ready)
  );

  typedef struct {
    logic [3:0] nib;
    int         lead;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 0;
  bit   armed = 0, done_seen = 0;
  int   low_run = 0, high_run = 0;
  logic prev_en = 0, prev_rdy = 0;
  logic [3:0] prev_data = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: load the scoreboard and pulse restart for one edge
  task automatic start_seq();
    exp_t e;
    @(posedge clk); #1;
    sb_q.delete();
    e.nib = 4'h3; e.lead = P + SU;  e.tag = "R3"; sb_q.push_back(e);
    e.nib = 4'h3; e.lead = G1 + SU; e.tag = "R6"; sb_q.push_back(e);
    e.nib = 4'h3; e.lead = G2 + SU; e.tag = "R6"; sb_q.push_back(e);
    e.nib = 4'h2; e.lead = G3 + SU; e.tag = "R6"; sb_q.push_back(e);
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  // monitor: measure the strobes and compare them with the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      armed = 0; prev_en = 0; prev_rdy = 0;
    end else if (restart) begin
      armed = 1; low_run = 0; high_run = 0;
      prev_en = 0; prev_rdy = 0; prev_data = lcd_data; done_seen = 0;
    end else if (armed) begin
      if (lcd_ready && !prev_rdy) begin
        check(sb_q.size() == 0, "R4", 4 - sb_q.size(), 4, "strobes before ready");
        check(low_run == G4, "R9", low_run, G4, "ready delay after last strobe");
        done_seen = 1;
      end
      if (lcd_ready) check(!lcd_en, "R10", lcd_en, 0, "strobe while ready");
      if (lcd_en && !prev_en) begin
        if (sb_q.size() == 0) begin
          check(0, "R9", 1, 0, "unexpected strobe");
        end else begin
          cur = sb_q.pop_front();
          check(low_run == cur.lead, cur.tag, low_run, cur.lead, "enable low time before strobe");
          check(prev_data == cur.nib, "R7", prev_data, cur.nib, "nibble before rise");
          check(lcd_data == cur.nib, "R4", lcd_data, cur.nib, "strobe nibble");
          check(!lcd_rs && !lcd_rw, "R8", {lcd_rs, lcd_rw}, 0, "rs/rw at strobe");
        end
        high_run = 1;
      end else if (lcd_en) begin
        high_run++;
        if (lcd_data != cur.nib) check(0, "R7", lcd_data, cur.nib, "nibble during strobe");
      end else if (prev_en) begin
        check(high_run == W, "R5", high_run, W, "strobe width");
        check(lcd_data == cur.nib, "R7", lcd_data, cur.nib, "nibble after fall");
        low_run = 1;
      end else begin
        low_run++;
      end
      prev_en = lcd_en; prev_rdy = lcd_ready; prev_data = lcd_data;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values, R8 control lines
    check(!lcd_en && !lcd_ready, "R1", {lcd_en, lcd_ready}, 0, "en/ready in reset");
    check(lcd_data == 4'h0, "R1", lcd_data, 0, "data in reset");
    check(!lcd_rs && !lcd_rw, "R8", {lcd_rs, lcd_rw}, 0, "rs/rw in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // full run, then ready must persist (R9)
    start_seq();
    wait (done_seen);
    repeat (40) @(negedge clk);
    check(lcd_ready, "R9", lcd_ready, 1, "ready still high");
    check(!lcd_en, "R10", lcd_en, 0, "enable idle when done");

    // R2 restart after completion
    start_seq();
    @(negedge clk);
    check(!lcd_ready, "R2", lcd_ready, 0, "ready after restart");
    wait (done_seen);

    // R2 restart inside the first gap
    start_seq();
    repeat (P + SU + W + 8) @(posedge clk);
    start_seq();
    wait (done_seen);

    // R2 restart in the middle of a strobe
    start_seq();
    repeat (P + SU + 2) @(posedge clk);
    #1 check(lcd_en, "R5", lcd_en, 1, "strobe active before abort");
    start_seq();
    @(negedge clk);
    check(!lcd_en, "R2", lcd_en, 0, "enable after restart");
    wait (done_seen);

    // R1 asynchronous reset during a strobe
    start_seq();
    repeat (P + SU + 2) @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(!lcd_en && !lcd_ready && lcd_data == 4'h0, "R1", {lcd_en, lcd_ready, lcd_data}, 0,
          "outputs right after reset assert");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    start_seq();
    wait (done_seen);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule